// File: doc/BRIEF.md
# Grouped-Priority Vectored Interrupt Controller

This block collects up to 48 level-sensitive interrupt sources, arranged as six groups of eight members (four general groups W, X, Y, Z and two groups reserved for RISC engines, A and B). It decides which pending, enabled source matters most and reports it as a 6-bit source number. Within each group, a priority register assigns members to eight ranked slots. Each group then arbitrates either as one block (grouped mode) or with its slots interleaved against the other groups in spread mode (spread mode).

One source number can be raised above every other source. That forced source can be sent to a separate high output line, and all other traffic goes to the low line. Each line has its own read-only vector register. Software reads the vector, services the source and acknowledges it by clearing the source's enable bit. Reading a vector has no side effect.

Top module: `icu_vec_ctrl`

## Requirements
- R1: After reset every register reads zero, both vectors read zero, and both lines are low. Every source is disabled, so raising all source inputs leaves both vectors at zero.
- R2: A source is reported only while its input is 1 and its enable bit is 1. Clearing the enable bit withdraws it. Enable bits are located as follows:
  - sources 1..16 use bits 15..0 of offset 0x20 (bit 16-n);
  - sources 32..47 use bits 31..16 of offset 0x20 (bit 63-n);
  - sources 17..31 use bits 31..17 of offset 0x24 (bit 48-n);
  - source 48 uses bit 15 of offset 0x24.
- R3: The low vector reads at offset 0x04 and the high vector at 0x60, in bits 31:26, with bits 25:0 zero. A vector reads 0 when nothing is pending on its line. Each line is high exactly when its vector is nonzero.
- R4: Source n = 1 + 8g + m, where g is the group index (W=0, X=1, Y=2, Z=3, RISC-A=4, RISC-B=5) and m is the member code 0..7. Source input bit n-1 belongs to source n. Number 0 means none.
- R5: The group priority registers are at 0x10, 0x14, 0x18 and 0x1C (W, X, Y, Z) and at 0x30 and 0x34 (RISC-A, RISC-B).
  - Slot s is a 3-bit field at lsb 29, 26, 23, 20, 13, 10, 7 or 4 for s = 0..7, and the field holds a member code.
  - A member's rank is the lowest slot holding its code; a member named in no slot ranks 8.
  - Lower rank wins, and equal ranks resolve to the lower source number.
- R6: Grouped-mode groups outrank all spread-mode groups. Among grouped groups, the lower group index wins outright, then rank decides within the group.
- R7: Configuration (offset 0x00) bits 18, 17, 16, 19, 21 and 22 put groups W, X, Y, Z, RISC-A and RISC-B in spread mode. Spread sources compare by rank first, then by group index.
- R8: Configuration bits 29:24 name a forced source. When it is pending and enabled, bits 9:8 = 2 place it on the high vector and remove it from low arbitration. Any other value of bits 9:8 makes it the low vector outright. The high vector is otherwise 0.
- R9: Writes to offsets without a register (including the vector offsets) change nothing, and reads of them return 0. Configuration keeps only bits 29:24, 22:21, 19:16 and 9:8, and priority registers keep only bits 31:20 and 15:4.
- R10: Source inputs are registered once, so a change shows on the vectors after the next rising edge. A register write takes effect from the edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_lvl | input | 48 | Level inputs, bit n-1 for source n |
| irq_lo | output | 1 | Low interrupt line |
| irq_hi | output | 1 | High interrupt line |

## Verification
A corrupted slot rank or spread bit changes only the ordering, so it shows up only when two sources from different groups or slots are pending at once. The stimulus therefore pairs sources across groups and modes. A wrong enable-bit location either hides a source or leaks a masked one. Because inputs pass through a single register stage, every such fault reaches the vector read one edge after the stimulus or write that exposes it.

// File: rtl/icu_pkg.sv
package icu_pkg;
   localparam int VEC_W  = 6;
   localparam int SLOT_W = 3;
   localparam int SLOTS  = 8;
   localparam int RANK_W = 4;

   localparam logic [7:0] OFF_CFG   = 8'h00;
   localparam logic [7:0] OFF_LOVEC = 8'h04;
   localparam logic [7:0] OFF_EN0   = 8'h20;
   localparam logic [7:0] OFF_EN1   = 8'h24;
   localparam logic [7:0] OFF_HIVEC = 8'h60;

   localparam logic [31:0] CFG_KEEP = 32'h3F6F_0300;
   localparam logic [31:0] PRI_KEEP = 32'hFFF0_FFF0;

   typedef struct packed {
      logic       bank;
      logic [4:0] pos;
   } en_loc_t;

   // enable-bit location of source n (1-based)
   function automatic en_loc_t en_loc(input int n);
      en_loc_t r;
      int b;
      if (n <= 16)      begin r.bank = 1'b0; b = 16 - n; end
      else if (n <= 31) begin r.bank = 1'b1; b = 48 - n; end
      else if (n <= 47) begin r.bank = 1'b0; b = 63 - n; end
      else              begin r.bank = 1'b1; b = 63 - n; end
      r.pos = 5'(b);
      return r;
   endfunction

   function automatic int slot_lsb(input int s);
      return (s < 4) ? (29 - 3 * s) : (13 - 3 * (s - 4));
   endfunction

   function automatic logic [7:0] pri_off(input int g);
      return (g < 4) ? 8'(16 + 4 * g) : 8'(48 + 4 * (g - 4));
   endfunction

   function automatic int spread_pos(input int g);
      case (g)
         0: return 18;
         1: return 17;
         2: return 16;
         3: return 19;
         4: return 21;
         default: return 22;
      endcase
   endfunction
endpackage

// File: rtl/icu_regs.sv
module icu_regs
   import icu_pkg::*;
#(
   parameter int NUM_GROUPS = 6,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [DATA_W-1:0]                  wdata,
   output logic [DATA_W-1:0]                  cfg_q,
   output logic [NUM_GROUPS-1:0][DATA_W-1:0]  pri_q,
   output logic [1:0][DATA_W-1:0]             en_q,
   output logic [DATA_W-1:0]                  rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         pri_q <= '0;
         en_q  <= '0;
      end else if (wr) begin
         if (addr == ADDR_W'(OFF_CFG)) cfg_q <= wdata & CFG_KEEP;
         if (addr == ADDR_W'(OFF_EN0)) en_q[0] <= wdata;
         if (addr == ADDR_W'(OFF_EN1)) en_q[1] <= wdata;
         for (int g = 0; g < NUM_GROUPS; g++)
            if (addr == ADDR_W'(pri_off(g))) pri_q[g] <= wdata & PRI_KEEP;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFF_CFG)) rdata = cfg_q;
      if (addr == ADDR_W'(OFF_EN0)) rdata = en_q[0];
      if (addr == ADDR_W'(OFF_EN1)) rdata = en_q[1];
      for (int g = 0; g < NUM_GROUPS; g++)
         if (addr == ADDR_W'(pri_off(g))) rdata = pri_q[g];
   end
endmodule

// File: rtl/icu_rank.sv
module icu_rank
   import icu_pkg::*;
#(
   parameter int GROUP_SIZE = 8,
   parameter int DATA_W     = 32
) (
   input  logic [DATA_W-1:0]                  pri,
   output logic [GROUP_SIZE-1:0][RANK_W-1:0]  rank
);
   always_comb begin
      for (int m = 0; m < GROUP_SIZE; m++) begin
         rank[m] = RANK_W'(SLOTS);
         for (int s = SLOTS - 1; s >= 0; s--)
            if (pri[slot_lsb(s) +: SLOT_W] == SLOT_W'(m)) rank[m] = RANK_W'(s);
      end
   end
endmodule

// File: rtl/icu_arb.sv
module icu_arb
   import icu_pkg::*;
#(
   parameter int NUM_GROUPS = 6,
   parameter int GROUP_SIZE = 8
) (
   input  logic [NUM_GROUPS*GROUP_SIZE-1:0]              act,
   input  logic [NUM_GROUPS-1:0]                         spread,
   input  logic [NUM_GROUPS*GROUP_SIZE-1:0][RANK_W-1:0]  rank,
   input  logic [VEC_W-1:0]                              excl,
   output logic [VEC_W-1:0]                              vec
);
   localparam int NUM_SRC = NUM_GROUPS * GROUP_SIZE;
   localparam int GRP_W   = $clog2(NUM_GROUPS);
   localparam int KEY_W   = RANK_W + GRP_W + RANK_W;

   logic [KEY_W-1:0] best, key;

   always_comb begin
      best = '1;
      vec  = '0;
      key  = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (spread[i / GROUP_SIZE])
            key = {rank[i] + RANK_W'(1), GRP_W'(i / GROUP_SIZE), rank[i]};
         else
            key = {RANK_W'(0), GRP_W'(i / GROUP_SIZE), rank[i]};
         if (act[i] && (VEC_W'(i + 1) != excl) && (key < best)) begin
            best = key;
            vec  = VEC_W'(i + 1);
         end
      end
   end
endmodule

// File: rtl/icu_vec_ctrl.sv
module icu_vec_ctrl
   import icu_pkg::*;
#(
   parameter int NUM_GROUPS = 6,
   parameter int GROUP_SIZE = 8,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                reg_wr,
   input  logic [ADDR_W-1:0]                   reg_addr,
   input  logic [DATA_W-1:0]                   reg_wdata,
   output logic [DATA_W-1:0]                   reg_rdata,
   input  logic [NUM_GROUPS*GROUP_SIZE-1:0]    src_lvl,
   output logic                                irq_lo,
   output logic                                irq_hi
);
   localparam int NUM_SRC = NUM_GROUPS * GROUP_SIZE;

   if (GROUP_SIZE != SLOTS) begin : g_bad_group
      $error("GROUP_SIZE must equal the slot count");
   end
   if (NUM_GROUPS != 6) begin : g_bad_groups
      $error("register map holds six groups");
   end
   if (DATA_W != 32 || ADDR_W < 7) begin : g_bad_bus
      $error("bus must be 32 bits wide with at least 7 address bits");
   end

   logic [DATA_W-1:0]                      cfg_q, regs_rdata;
   logic [NUM_GROUPS-1:0][DATA_W-1:0]      pri_q;
   logic [1:0][DATA_W-1:0]                 en_q;
   logic [NUM_SRC-1:0]                     src_q, en, act;
   logic [NUM_GROUPS-1:0]                  spread;
   logic [NUM_SRC-1:0][RANK_W-1:0]         rank_all;
   logic [VEC_W-1:0]                       hp, arb_vec, excl, lo_vec, hi_vec;
   logic                                   forced_act, to_hi;

   icu_regs #(.NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .cfg_q(cfg_q), .pri_q(pri_q), .en_q(en_q), .rdata(regs_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_lvl;
   end

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
         en[i] = en_q[en_loc(i + 1).bank][en_loc(i + 1).pos];
      end
   end
   assign act = src_q & en;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign spread[g] = cfg_q[spread_pos(g)];
      icu_rank #(.GROUP_SIZE(GROUP_SIZE), .DATA_W(DATA_W)) rank_i (
         .pri(pri_q[g]), .rank(rank_all[g*GROUP_SIZE +: GROUP_SIZE])
      );
   end

   assign hp = cfg_q[29:24];

   always_comb begin
      forced_act = 1'b0;
      for (int i = 0; i < NUM_SRC; i++)
         if (hp == VEC_W'(i + 1) && act[i]) forced_act = 1'b1;
   end
   assign to_hi = forced_act && (cfg_q[9:8] == 2'd2);
   assign excl  = to_hi ? hp : '0;

   icu_arb #(.NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE)) arb_i (
      .act(act), .spread(spread), .rank(rank_all), .excl(excl), .vec(arb_vec)
   );

   assign lo_vec = (forced_act && !to_hi) ? hp : arb_vec;
   assign hi_vec = to_hi ? hp : '0;
   assign irq_lo = |lo_vec;
   assign irq_hi = |hi_vec;

   always_comb begin
      if (reg_addr == ADDR_W'(OFF_LOVEC))
         reg_rdata = {lo_vec, {(DATA_W-VEC_W){1'b0}}};
      else if (reg_addr == ADDR_W'(OFF_HIVEC))
         reg_rdata = {hi_vec, {(DATA_W-VEC_W){1'b0}}};
      else
         reg_rdata = regs_rdata;
   end
endmodule

// File: rtl/icu_vec_ctrl_chk.sv
module icu_vec_ctrl_chk #(
   parameter int NUM_SRC = 48,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] act,
   input logic [DATA_W-1:0]  cfg_q,
   input logic [5:0]         lo_vec,
   input logic [5:0]         hi_vec,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_rdata
);
   AST_LO_SOURCE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_vec != 6'd0 && int'(lo_vec) <= NUM_SRC) |-> act[lo_vec - 6'd1]); // R2
   AST_HI_ONLY_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_vec != 6'd0) |-> (hi_vec == cfg_q[29:24] && cfg_q[9:8] == 2'd2)); // R8
   AST_LINES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_vec != 6'd0 && hi_vec != 6'd0) |-> (lo_vec != hi_vec)); // R8
   AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(lo_vec) <= NUM_SRC) && (int'(hi_vec) <= NUM_SRC)); // R4
   AST_UPPER_OFFSETS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr[ADDR_W-1] |-> (reg_rdata == '0)); // R9
endmodule

bind icu_vec_ctrl icu_vec_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .act(act), .cfg_q(cfg_q), .lo_vec(lo_vec),
   .hi_vec(hi_vec), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/icu_vec_ctrl_tb.sv
module icu_vec_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [47:0] src_lvl = '0;
   logic        irq_lo, irq_hi;
   int          checks = 0;
   int          errors = 0;

   always #10 clk = ~clk;

   icu_vec_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_lvl(src_lvl),
      .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   // {req[57:54], kind[53:52], addr[51:44], data[43:12], lo[11:6], hi[5:0]}
   // kind 0: register write, 1: src bits 31:0, 2: src bits 47:32, 3: check vectors
   localparam int N = 41;
   localparam logic [57:0] TBL [0:N-1] = '{
      {4'd2, 2'd0, 8'h20, 32'hFFFF_FFFF, 6'd0,  6'd0},
      {4'd3, 2'd3, 8'h00, 32'h0,         6'd0,  6'd0},   // R3 idle
      {4'd4, 2'd1, 8'h00, 32'h0000_0001, 6'd0,  6'd0},
      {4'd4, 2'd3, 8'h00, 32'h0,         6'd1,  6'd0},   // R4 source 1
      {4'd5, 2'd1, 8'h00, 32'h0000_0003, 6'd0,  6'd0},
      {4'd5, 2'd3, 8'h00, 32'h0,         6'd1,  6'd0},   // R5 unlisted ranks last
      {4'd5, 2'd0, 8'h10, 32'h2000_0000, 6'd0,  6'd0},
      {4'd5, 2'd3, 8'h00, 32'h0,         6'd2,  6'd0},   // R5 slot reorder
      {4'd6, 2'd1, 8'h00, 32'h0000_0201, 6'd0,  6'd0},
      {4'd6, 2'd3, 8'h00, 32'h0,         6'd1,  6'd0},   // R6 W before X
      {4'd7, 2'd0, 8'h00, 32'h0004_0000, 6'd0,  6'd0},
      {4'd7, 2'd3, 8'h00, 32'h0,         6'd10, 6'd0},   // R7 spread W behind grouped X
      {4'd7, 2'd0, 8'h00, 32'h0006_0000, 6'd0,  6'd0},
      {4'd7, 2'd3, 8'h00, 32'h0,         6'd1,  6'd0},   // R7 rank 1 beats rank 8
      {4'd7, 2'd0, 8'h14, 32'h2000_0000, 6'd0,  6'd0},
      {4'd7, 2'd3, 8'h00, 32'h0,         6'd10, 6'd0},   // R7 slot 0 beats slot 1
      {4'd7, 2'd0, 8'h10, 32'h0000_0000, 6'd0,  6'd0},
      {4'd7, 2'd3, 8'h00, 32'h0,         6'd1,  6'd0},   // R7 equal slot, group order
      {4'd2, 2'd0, 8'h20, 32'hFFFF_7FFF, 6'd0,  6'd0},
      {4'd2, 2'd3, 8'h00, 32'h0,         6'd10, 6'd0},   // R2 source 1 disabled
      {4'd8, 2'd0, 8'h00, 32'h0A06_0200, 6'd0,  6'd0},
      {4'd8, 2'd3, 8'h00, 32'h0,         6'd0,  6'd10},  // R8 forced to high
      {4'd8, 2'd0, 8'h20, 32'hFFFF_FFFF, 6'd0,  6'd0},
      {4'd8, 2'd3, 8'h00, 32'h0,         6'd1,  6'd10},  // R8 both lines
      {4'd8, 2'd0, 8'h00, 32'h0A06_0000, 6'd0,  6'd0},
      {4'd8, 2'd3, 8'h00, 32'h0,         6'd10, 6'd0},   // R8 forced on low
      {4'd8, 2'd0, 8'h00, 32'h0506_0200, 6'd0,  6'd0},
      {4'd8, 2'd3, 8'h00, 32'h0,         6'd1,  6'd0},   // R8 forced not pending
      {4'd4, 2'd1, 8'h00, 32'h0000_0000, 6'd0,  6'd0},
      {4'd4, 2'd2, 8'h00, 32'h0000_0100, 6'd0,  6'd0},
      {4'd4, 2'd3, 8'h00, 32'h0,         6'd41, 6'd0},   // R4 RISC-B member 0
      {4'd2, 2'd2, 8'h00, 32'h0000_8100, 6'd0,  6'd0},
      {4'd2, 2'd3, 8'h00, 32'h0,         6'd41, 6'd0},   // R2 source 48 disabled
      {4'd5, 2'd0, 8'h34, 32'hE000_0000, 6'd0,  6'd0},
      {4'd5, 2'd3, 8'h00, 32'h0,         6'd41, 6'd0},   // R5 only live source
      {4'd2, 2'd0, 8'h24, 32'h0000_8000, 6'd0,  6'd0},
      {4'd2, 2'd3, 8'h00, 32'h0,         6'd48, 6'd0},   // R2 source 48 enabled, slot 0
      {4'd9, 2'd0, 8'h44, 32'hFFFF_FFFF, 6'd0,  6'd0},
      {4'd9, 2'd3, 8'h00, 32'h0,         6'd48, 6'd0},   // R9 unused write
      {4'd9, 2'd0, 8'h04, 32'hFFFF_FFFF, 6'd0,  6'd0},
      {4'd9, 2'd3, 8'h00, 32'h0,         6'd48, 6'd0}    // R9 vector write ignored
   };

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic chk_vec(input string req, input logic [5:0] lo, input logic [5:0] hi);
      logic [31:0] d;
      repeat (2) @(posedge clk);
      rd_reg(8'h04, d);
      chk(req, "low vector", d, {lo, 26'd0});
      chk(req, "low line", 32'(irq_lo), 32'(lo != 6'd0));
      rd_reg(8'h60, d);
      chk(req, "high vector", d, {hi, 26'd0});
      chk(req, "high line", 32'(irq_hi), 32'(hi != 6'd0));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd_reg(8'h00, d); chk("R1", "cfg reset", d, 32'h0);
      rd_reg(8'h20, d); chk("R1", "enable0 reset", d, 32'h0);
      rd_reg(8'h24, d); chk("R1", "enable1 reset", d, 32'h0);
      rd_reg(8'h10, d); chk("R1", "priority reset", d, 32'h0);
      chk_vec("R1", 6'd0, 6'd0);
      @(posedge clk); #1 src_lvl = '1;
      chk_vec("R1", 6'd0, 6'd0);
      @(posedge clk); #1 src_lvl = '0;

      for (int i = 0; i < N; i++) begin
         string rq;
         rq = $sformatf("R%0d", TBL[i][57:54]);
         case (TBL[i][53:52])
            2'd0: wr_reg(TBL[i][51:44], TBL[i][43:12]);
            2'd1: begin @(posedge clk); #1 src_lvl[31:0] = TBL[i][43:12]; end
            2'd2: begin @(posedge clk); #1 src_lvl[47:32] = TBL[i][27:12]; end
            default: chk_vec(rq, TBL[i][11:6], TBL[i][5:0]);
         endcase
      end

      // R10 one register stage on the sources
      @(posedge clk); #1 src_lvl[47:32] = 16'h0100;
      rd_reg(8'h04, d); chk("R10", "before edge", d, {6'd48, 26'd0});
      rd_reg(8'h04, d); chk("R10", "after edge", d, {6'd41, 26'd0});

      // R9 unused offsets and kept fields
      rd_reg(8'h44, d); chk("R9", "unused read", d, 32'h0);
      rd_reg(8'h84, d); chk("R9", "upper read", d, 32'h0);
      wr_reg(8'h00, 32'hFFFF_FFFF);
      rd_reg(8'h00, d); chk("R9", "cfg kept bits", d, 32'h3F6F_0300);
      wr_reg(8'h34, 32'hFFFF_FFFF);
      rd_reg(8'h34, d); chk("R9", "priority kept bits", d, 32'hFFF0_FFF0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule